// File: doc/BRIEF.md
# Priority-Routing Peripheral Interrupt Controller

This block gathers up to 32 level-sensitive peripheral interrupt lines and sorts each of them onto one of seven core priority levels, numbered 7 to 13. Every source owns a 4-bit routing field. Software programs these fields, together with an enable mask and a wakeup-enable mask, through a small register port with separate read and write strobes. The block keeps one request output per level. Each output is high whenever at least one enabled, asserted source is routed to that level.

When the core takes an interrupt on a shared level, it asks the block which source to service. It places a level index on the query port. A four-state machine then reports the lowest-numbered active source on that level. If no active source is routed there, it marks the answer as spurious and increments a counter that software can read.

The query machine has four states. Q_IDLE accepts a query and latches the level index. Q_LOOKUP resolves the candidates. If a candidate exists it moves to Q_HIT, and otherwise it moves to Q_MISS. Both Q_HIT and Q_MISS return to Q_IDLE on the following cycle.

Top module: `sic_top`

## Requirements
- R1: The status register (word address 0) mirrors the request inputs after a two-flop synchronizer. A change on `irq_in` appears two clock edges later. Writes to address 0 have no effect.
- R2: After reset, the mask register (address 1) reads 0, the wakeup-enable register (address 2) reads all ones, status reads 0, and every level output is 0.
- R3: Routing fields live in registers at word addresses 4 to 7. Source n uses register 4+(n>>3), bits (n&7)*4 to (n&7)*4+3.
- R4: A source is active only when its status bit and its mask bit (bit n for source n) are both 1. Output `lvl_req[v]`, which stands for core level 7+v, is the OR of the active sources whose field equals v.
- R5: A source whose field holds any value from 7 to 15 drives no level output.
- R6: A query on a level reports in `rsp_src` the lowest-numbered active source routed to that level, with `rsp_spurious` low.
- R7: A query on a level with no active routed source sets `rsp_spurious` and reports source 0. This includes a level index of 7. It also adds one to the spurious counter, which reads at address 3.
- R8: Read data appears on `bus_rdata` one cycle after `bus_rd`. Addresses 8 to 15 read as 0, and writes to them change no register.
- R9: `wake_req` is high whenever any status bit is set whose wakeup-enable bit is also set.
- R10: A query is accepted only while `qry_ready` is high. `rsp_valid` pulses for exactly one cycle, two clock edges after the accepting edge, and `qry_ready` stays low until the pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Asynchronous level-sensitive peripheral requests |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| lvl_req | output | 7 | Per-level requests; bit v stands for core level 7+v |
| wake_req | output | 1 | Wakeup request |
| qry_valid | input | 1 | Query strobe |
| qry_level | input | 3 | Queried level index (0 stands for level 7) |
| qry_ready | output | 1 | Query machine is idle |
| rsp_valid | output | 1 | Query answer is valid for this cycle |
| rsp_spurious | output | 1 | No active source was found for the queried level |
| rsp_src | output | 5 | Winning source number |

## Verification
The hardest situation to reach from the ports is a level shared by several sources. In that case the winner must change only because the mask changes, while the requests themselves stay put. The bench routes sources 5, 9 and 20 to the same level and raises all three together. It then removes the lowest winner with mask writes, one at a time, and checks that the answer moves to the next source in turn. A routing field set to an unused value must be told apart from a masked source. The bench covers this by raising the line with its mask open and checking both the level outputs and the wakeup output.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int DW        = 32;
    localparam int FW        = 4;
    localparam int SRC_PER_W = DW / FW;

    localparam int A_STATUS  = 0;
    localparam int A_MASK    = 1;
    localparam int A_WAKE    = 2;
    localparam int A_SPUR    = 3;
    localparam int A_ROUTE0  = 4;

    typedef enum logic [1:0] {
        Q_IDLE   = 2'd0,
        Q_LOOKUP = 2'd1,
        Q_HIT    = 2'd2,
        Q_MISS   = 2'd3
    } q_state_e;

endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4,
    parameter int SPUR_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NUM_SRC-1:0]    status,
    input  logic [SPUR_W-1:0]     spur_cnt,
    output logic [DW-1:0]         rdata,
    output logic [NUM_SRC-1:0]    mask_q,
    output logic [NUM_SRC-1:0]    wake_q,
    output logic [NUM_SRC*FW-1:0] route_flat
);
    localparam int NUM_RT  = NUM_SRC / SRC_PER_W;
    localparam int A_LIMIT = A_ROUTE0 + NUM_RT;

    logic [NUM_RT-1:0][DW-1:0] rt_q;
    logic [DW-1:0]             rd_next;
    logic                      unmapped;

    assign unmapped   = (int'(addr) >= A_LIMIT);
    assign route_flat = rt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            wake_q <= '1;
        end else if (wr_en) begin
            if (int'(addr) == A_MASK) mask_q <= wdata[NUM_SRC-1:0];
            if (int'(addr) == A_WAKE) wake_q <= wdata[NUM_SRC-1:0];
        end
    end

    for (genvar k = 0; k < NUM_RT; k++) begin : g_route_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                rt_q[k] <= '0;
            else if (wr_en && int'(addr) == A_ROUTE0 + k)
                rt_q[k] <= wdata;
        end
    end

    always_comb begin
        rd_next = '0;
        if (int'(addr) == A_STATUS) rd_next = DW'(status);
        if (int'(addr) == A_MASK)   rd_next = DW'(mask_q);
        if (int'(addr) == A_WAKE)   rd_next = DW'(wake_q);
        if (int'(addr) == A_SPUR)   rd_next = DW'(spur_cnt);
        for (int k = 0; k < NUM_RT; k++)
            if (int'(addr) == A_ROUTE0 + k) rd_next = rt_q[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unmapped) |=> ($stable(mask_q) && $stable(wake_q) && $stable(rt_q)));

endmodule

// File: rtl/sic_route.sv
module sic_route
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 7
) (
    input  logic [NUM_SRC-1:0]                status,
    input  logic [NUM_SRC-1:0]                mask_q,
    input  logic [NUM_SRC*FW-1:0]             route_flat,
    output logic [NUM_LVL-1:0][NUM_SRC-1:0]   cand,
    output logic [NUM_LVL-1:0]                lvl_req
);
    logic [NUM_SRC-1:0] active;

    assign active = status & mask_q;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign cand[l][s] = active[s] && (route_flat[s*FW +: FW] == FW'(l));
        end
        assign lvl_req[l] = |cand[l];
    end
endmodule

// File: rtl/sic_query.sv
module sic_query
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 7,
    parameter int SPUR_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              qry_valid,
    input  logic [$clog2(NUM_LVL+1)-1:0]      qry_level,
    input  logic [NUM_LVL-1:0][NUM_SRC-1:0]   cand,
    output logic                              qry_ready,
    output logic                              rsp_valid,
    output logic                              rsp_spur,
    output logic [$clog2(NUM_SRC)-1:0]        rsp_src,
    output logic [SPUR_W-1:0]                 spur_cnt
);
    localparam int LVL_W = $clog2(NUM_LVL + 1);
    localparam int SRC_W = $clog2(NUM_SRC);

    q_state_e           st_q, st_d;
    logic [LVL_W-1:0]   lvl_q;
    logic [SRC_W-1:0]   src_q;
    logic [NUM_SRC-1:0] sel;
    logic [NUM_SRC-1:0] sel_hold_q;
    logic [SRC_W-1:0]   enc;
    logic               found;

    always_comb begin
        sel = '0;
        for (int l = 0; l < NUM_LVL; l++)
            if (int'(lvl_q) == l) sel = cand[l];
    end

    always_comb begin
        enc = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--)
            if (sel[i]) enc = SRC_W'(i);
    end

    assign found = |sel;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_IDLE:   if (qry_valid) st_d = Q_LOOKUP;
            Q_LOOKUP: st_d = found ? Q_HIT : Q_MISS;
            Q_HIT:    st_d = Q_IDLE;
            Q_MISS:   st_d = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= Q_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q      <= '0;
            src_q      <= '0;
            spur_cnt   <= '0;
            sel_hold_q <= '0;
        end else begin
            if (st_q == Q_IDLE && qry_valid) lvl_q <= qry_level;
            if (st_q == Q_LOOKUP) begin
                sel_hold_q <= sel;
                src_q      <= found ? enc : '0;
                if (!found) spur_cnt <= spur_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        qry_ready = (st_q == Q_IDLE);
        rsp_valid = (st_q == Q_HIT) || (st_q == Q_MISS);
        rsp_spur  = (st_q == Q_MISS);
        rsp_src   = src_q;
    end

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    spur_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spur_cnt != $past(spur_cnt)) |-> (rsp_spur && spur_cnt == $past(spur_cnt) + 1'b1));

    // R6
    hit_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_spur) |-> (sel_hold_q[rsp_src] &&
            ((sel_hold_q & ((NUM_SRC'(1) << rsp_src) - NUM_SRC'(1))) == '0)));

    // R10
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_ready && qry_valid) |=> (!qry_ready && !rsp_valid));

endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 7,
    parameter int ADDR_W  = 4,
    parameter int SPUR_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             irq_in,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DW-1:0]                  bus_wdata,
    output logic [DW-1:0]                  bus_rdata,
    output logic [NUM_LVL-1:0]             lvl_req,
    output logic                           wake_req,
    input  logic                           qry_valid,
    input  logic [$clog2(NUM_LVL+1)-1:0]   qry_level,
    output logic                           qry_ready,
    output logic                           rsp_valid,
    output logic                           rsp_spurious,
    output logic [$clog2(NUM_SRC)-1:0]     rsp_src
);
    logic [NUM_SRC-1:0]              status;
    logic [NUM_SRC-1:0]              mask_q;
    logic [NUM_SRC-1:0]              wake_q;
    logic [NUM_SRC*FW-1:0]           route_flat;
    logic [NUM_LVL-1:0][NUM_SRC-1:0] cand;
    logic [SPUR_W-1:0]               spur_cnt;

    sic_sync #(.W(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (status)
    );

    sic_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SPUR_W(SPUR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .status     (status),
        .spur_cnt   (spur_cnt),
        .rdata      (bus_rdata),
        .mask_q     (mask_q),
        .wake_q     (wake_q),
        .route_flat (route_flat)
    );

    sic_route #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_route (
        .status     (status),
        .mask_q     (mask_q),
        .route_flat (route_flat),
        .cand       (cand),
        .lvl_req    (lvl_req)
    );

    sic_query #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .SPUR_W(SPUR_W)) u_query (
        .clk       (clk),
        .rst_n     (rst_n),
        .qry_valid (qry_valid),
        .qry_level (qry_level),
        .cand      (cand),
        .qry_ready (qry_ready),
        .rsp_valid (rsp_valid),
        .rsp_spur  (rsp_spurious),
        .rsp_src   (rsp_src),
        .spur_cnt  (spur_cnt)
    );

    assign wake_req = |(status & wake_q);

endmodule

// File: tb/sim_sic_top.sv
module sim_sic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  lvl_req;
    logic        wake_req;
    logic        qry_valid = 1'b0;
    logic [2:0]  qry_level = '0;
    logic        qry_ready;
    logic        rsp_valid;
    logic        rsp_spurious;
    logic [4:0]  rsp_src;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rt_img [4];

    always #2 clk = ~clk;

    sic_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lvl_req(lvl_req), .wake_req(wake_req),
        .qry_valid(qry_valid), .qry_level(qry_level), .qry_ready(qry_ready),
        .rsp_valid(rsp_valid), .rsp_spurious(rsp_spurious), .rsp_src(rsp_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_irq(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_field(input int n, input logic [3:0] v);
        rt_img[n >> 3][(n & 7) * 4 +: 4] = v;
        wr(4 + (n >> 3), rt_img[n >> 3]);
    endtask

    task automatic clear_fields();
        for (int k = 0; k < 4; k++) begin
            rt_img[k] = 32'hFFFF_FFFF;
            wr(4 + k, rt_img[k]);
        end
    endtask

    task automatic query(input string req, input logic [2:0] lvl,
                         input logic exp_spur, input logic [4:0] exp_src);
        @(negedge clk);
        qry_valid = 1'b1; qry_level = lvl;
        @(negedge clk);
        qry_valid = 1'b0;
        chk({req, " busy"}, {31'd0, qry_ready}, 32'd0);
        chk({req, " no early rsp"}, {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({req, " spurious"}, {31'd0, rsp_spurious}, {31'd0, exp_spur});
        chk({req, " src"}, {27'd0, rsp_src}, {27'd0, exp_src});
        @(negedge clk);
        chk({req, " pulse end"}, {30'd0, rsp_valid, qry_ready}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(1, d); chk("R2 mask reset", d, 32'h0);
        rd(2, d); chk("R2 wake reset", d, 32'hFFFF_FFFF);
        rd(0, d); chk("R2 status reset", d, 32'h0);
        chk("R2 lvl_req reset", {25'd0, lvl_req}, 32'h0);
        chk("R10 ready after reset", {30'd0, qry_ready, rsp_valid}, 32'd2);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk);
        irq_in = 32'hA5A5_0001;
        @(negedge clk);
        rd(0, d); chk("R1 status sync", d, 32'hA5A5_0001);
        wr(0, 32'h0);
        rd(0, d); chk("R1 status read-only", d, 32'hA5A5_0001);
        set_irq(32'h0);
        rd(0, d); chk("R1 status cleared", d, 32'h0);
    endtask

    task automatic t_layout();
        clear_fields();
        wr(1, 32'hFFFF_FFFF);
        set_field(13, 4'd3);
        set_irq(32'h0000_2000);
        chk("R3 R4 src13 to level 10", {25'd0, lvl_req}, 32'h08);
        set_field(0, 4'd0);
        set_field(31, 4'd6);
        set_irq(32'h8000_2001);
        chk("R3 R4 sources 0 and 31", {25'd0, lvl_req}, 32'h49);
        wr(1, 32'h7FFF_DFFF);
        chk("R4 masked sources drop", {25'd0, lvl_req}, 32'h01);
        wr(1, 32'hFFFF_FFFF);
    endtask

    task automatic t_nolevel();
        clear_fields();
        set_irq(32'h0000_2000);
        set_field(13, 4'd7);
        chk("R5 field 7 routes nowhere", {25'd0, lvl_req}, 32'h0);
        set_field(13, 4'd15);
        chk("R5 field 15 routes nowhere", {25'd0, lvl_req}, 32'h0);
        chk("R9 wake with enable", {31'd0, wake_req}, 32'd1);
        wr(2, 32'hFFFF_DFFF);
        chk("R9 wake disabled", {31'd0, wake_req}, 32'd0);
        wr(2, 32'hFFFF_FFFF);
        set_irq(32'h0);
    endtask

    task automatic t_priority();
        clear_fields();
        wr(1, 32'hFFFF_FFFF);
        set_field(5, 4'd2);
        set_field(9, 4'd2);
        set_field(20, 4'd2);
        set_irq(32'h0010_0220);
        query("R6 lowest of 5,9,20", 3'd2, 1'b0, 5'd5);
        wr(1, 32'hFFFF_FFDF);
        query("R6 next winner 9", 3'd2, 1'b0, 5'd9);
        wr(1, 32'hFFFF_FDDF);
        query("R6 last winner 20", 3'd2, 1'b0, 5'd20);
        set_field(31, 4'd2);
        set_irq(32'h8000_0000);
        query("R6 top source 31", 3'd2, 1'b0, 5'd31);
        set_irq(32'h0);
        wr(1, 32'hFFFF_FFFF);
    endtask

    task automatic t_spurious();
        logic [31:0] d;
        rd(3, d); chk("R7 counter initial", d, 32'd0);
        query("R7 empty level 4", 3'd4, 1'b1, 5'd0);
        rd(3, d); chk("R7 counter one", d, 32'd1);
        query("R7 level index 7", 3'd7, 1'b1, 5'd0);
        rd(3, d); chk("R7 counter two", d, 32'd2);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(1, 32'h1234_5678);
        wr(9, 32'hDEAD_BEEF);
        wr(15, 32'h0);
        rd(1, d); chk("R8 mask kept", d, 32'h1234_5678);
        rd(2, d); chk("R8 wake kept", d, 32'hFFFF_FFFF);
        rd(4, d); chk("R8 route kept", d, rt_img[0]);
        rd(9, d); chk("R8 unmapped reads zero", d, 32'h0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'd1;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 4'd2;
        chk("R8 one-cycle read", bus_rdata, 32'h1234_5678);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) rt_img[k] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_layout();
        t_nolevel();
        t_priority();
        t_spurious();
        t_unmapped();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule